// File: doc/BRIEF.md
# Grouped Interrupt Level Controller

This block is the system-level interrupt controller for a small 8-bit processor core. It serves five interrupt levels with sparse numbers 0, 1, 4, 6 and 7. A request on any level is latched into a pending register. Each pending level is gated by its own mask bit and then by one global enable bit. The levels that survive are arbitrated to a single winner, which is presented to the core together with an interrupt line.

Priority is not a fixed ladder. The levels form three groups: A holds levels 0 and 1, B holds level 4, and C holds levels 6 and 7. A priority register picks one of six orderings of the three groups, and it also picks which member wins inside A and inside C. The core reads and writes the mask, priority and system mode registers through a small register port. It reads the pending register through the same port. Single-cycle enable and disable commands drive the global enable. When the core takes an interrupt it pulses an acknowledge, and that clears the pending bit of the level being presented.

Top module: `irqc_top`

## Requirements
- R1: After reset the mask, priority, pending and system mode registers all read 0x00, intOut is 0 and intLevel is 0.
- R2: Register select codes are 0 for mask, 1 for priority, 2 for pending and 3 for system mode. In mask and pending only bit positions 0, 1, 4, 6 and 7 exist. Bits 2, 3 and 5 read as 0, and requests on those positions are ignored. In system mode only bit 0 (global enable) exists, and the other bits read as 0.
- R3: A write to the pending register (select 2) has no effect.
- R4: While global enable is 0, intOut is 0 whatever the mask and pending bits hold.
- R5: enCmd sets global enable and disCmd clears it. If both arrive in the same cycle, disCmd wins. A write to system mode bit 0 also sets or clears global enable, but a command in the same cycle overrides the write.
- R6: A level whose mask bit is 0 takes no part in arbitration. Its pending bit is kept.
- R7: intOut is 1 in the same cycle that global enable is 1 and some level is both pending and unmasked. In that cycle intLevel gives the winning level number. When intOut is 0, intLevel is 0.
- R8: Priority bits [2:0] order the groups. The codes are 0 = A,B,C; 1 = A,C,B; 2 = B,A,C; 3 = B,C,A; 4 = C,A,B; 5 = C,B,A. Codes 6 and 7 behave like code 0. Bit 3 = 0 lets level 0 win within A, and bit 3 = 1 lets level 1 win. Bit 4 = 0 lets level 6 win within C, and bit 4 = 1 lets level 7 win. Bits 7:5 read as 0.
- R9: An intAck pulse while intOut is 1 clears the pending bit of the presented level at the next edge. An intAck while intOut is 0 has no effect.
- R10: If a request arrives on the acknowledged level in the same cycle as the intAck, its pending bit stays set.
- R11: A request input high for one clock sets its pending bit. The bit then stays set, regardless of mask and global enable, until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqIn | input | 8 | Per-level request inputs, indexed by level number |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 2 | Register select (0 mask, 1 priority, 2 pending, 3 system mode) |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Read data of the selected register (combinational) |
| enCmd | input | 1 | Enable-interrupts command pulse |
| disCmd | input | 1 | Disable-interrupts command pulse |
| intAck | input | 1 | Interrupt acknowledge pulse from the core |
| intOut | output | 1 | Interrupt request to the core |
| intLevel | output | 3 | Winning level number |

## Verification
The assertions assume that every input is steady across each rising edge. They also assume that intAck, enCmd and disCmd are single-cycle pulses that the core raises on purpose, so an acknowledge may come with no interrupt shown and must then have no effect. The stimulus changes inputs one time unit after an edge and holds each command for exactly one cycle. It drives requests on the unimplemented positions 2, 3 and 5 on purpose, and it acknowledges while intOut is low, to show that the block tolerates such input without the assertions relying on its absence.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int RegW = 8;
  localparam int LevelW = 3;
  localparam int PrioW = 5;
  localparam int NumGroups = 3;

  localparam logic [LevelW-1:0] LvlA0 = 3'd0;
  localparam logic [LevelW-1:0] LvlA1 = 3'd1;
  localparam logic [LevelW-1:0] LvlB  = 3'd4;
  localparam logic [LevelW-1:0] LvlC0 = 3'd6;
  localparam logic [LevelW-1:0] LvlC1 = 3'd7;

  localparam logic [RegW-1:0] ImplLevels =
    (RegW'(1) << LvlA0) | (RegW'(1) << LvlA1) | (RegW'(1) << LvlB) |
    (RegW'(1) << LvlC0) | (RegW'(1) << LvlC1);

  localparam logic [1:0] SelMask = 2'd0;
  localparam logic [1:0] SelPrio = 2'd1;
  localparam logic [1:0] SelPend = 2'd2;
  localparam logic [1:0] SelSys  = 2'd3;

  typedef struct packed {
    logic [RegW-1:0] clrPend;
    logic            gieSet;
    logic            gieClr;
  } ctlStrobe_t;
endpackage

// File: rtl/irqc_datapath.sv
module irqc_datapath
  import irqc_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic [RegW-1:0] reqIn,
  input  logic            regWrEn,
  input  logic [1:0]      regSel,
  input  logic [RegW-1:0] regWrData,
  input  ctlStrobe_t      strobe,
  output logic [RegW-1:0] maskQ,
  output logic [PrioW-1:0] prioQ,
  output logic [RegW-1:0] pendQ,
  output logic            gieQ,
  output logic [RegW-1:0] regRdData
);
  logic wrMask, wrPrio, wrSys;
  assign wrMask = regWrEn && (regSel == SelMask);
  assign wrPrio = regWrEn && (regSel == SelPrio);
  assign wrSys  = regWrEn && (regSel == SelSys);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskQ <= '0;
      prioQ <= '0;
      pendQ <= '0;
      gieQ  <= 1'b0;
    end else begin
      pendQ <= ((pendQ & ~strobe.clrPend) | reqIn) & ImplLevels;
      if (wrMask) maskQ <= regWrData & ImplLevels;
      if (wrPrio) prioQ <= regWrData[PrioW-1:0];
      if (strobe.gieClr)      gieQ <= 1'b0;
      else if (strobe.gieSet) gieQ <= 1'b1;
      else if (wrSys)         gieQ <= regWrData[0];
    end
  end

  always_comb begin
    case (regSel)
      SelMask: regRdData = maskQ;
      SelPrio: regRdData = RegW'(prioQ);
      SelPend: regRdData = pendQ;
      default: regRdData = RegW'(gieQ);
    endcase
  end

  // R9 / R10: an acknowledged level with no fresh request is clear afterwards
  a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rstN)
    ((strobe.clrPend != '0) && ((strobe.clrPend & reqIn) == '0))
      |=> ((pendQ & $past(strobe.clrPend)) == '0));

  a_r11_req_sets: assert property (@(posedge clk) disable iff (!rstN)
    ((reqIn & ImplLevels) != '0)
      |=> ((pendQ & $past(reqIn & ImplLevels)) == $past(reqIn & ImplLevels)));

  a_r3_pend_readonly: assert property (@(posedge clk) disable iff (!rstN)
    (wrSys == 1'b0 && regWrEn && regSel == SelPend &&
     strobe.clrPend == '0 && reqIn == '0) |=> $stable(pendQ));
endmodule

// File: rtl/irqc_control.sv
module irqc_control
  import irqc_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [RegW-1:0]  maskQ,
  input  logic [PrioW-1:0] prioQ,
  input  logic [RegW-1:0]  pendQ,
  input  logic             gieQ,
  input  logic             enCmd,
  input  logic             disCmd,
  input  logic             intAck,
  output ctlStrobe_t       strobe,
  output logic             intOut,
  output logic [LevelW-1:0] intLevel
);
  localparam int GrpA = 0;
  localparam int GrpB = 1;
  localparam int GrpC = 2;

  logic [RegW-1:0]      active;
  logic [NumGroups-1:0] grpValid;
  logic [LevelW-1:0]    grpLvl [NumGroups];
  logic [1:0]           ord [NumGroups];
  logic [LevelW-1:0]    winner;
  logic                 found;

  function automatic logic [LevelW-1:0] pickPair(
    input logic h0, input logic h1, input logic swap,
    input logic [LevelW-1:0] l0, input logic [LevelW-1:0] l1);
    if (swap) return h1 ? l1 : l0;
    else      return h0 ? l0 : l1;
  endfunction

  assign active = pendQ & maskQ & ImplLevels;

  always_comb begin
    grpValid[GrpA] = active[LvlA0] | active[LvlA1];
    grpValid[GrpB] = active[LvlB];
    grpValid[GrpC] = active[LvlC0] | active[LvlC1];
    grpLvl[GrpA] = pickPair(active[LvlA0], active[LvlA1], prioQ[3], LvlA0, LvlA1);
    grpLvl[GrpB] = LvlB;
    grpLvl[GrpC] = pickPair(active[LvlC0], active[LvlC1], prioQ[4], LvlC0, LvlC1);
  end

  always_comb begin
    case (prioQ[2:0])
      3'd1:    begin ord[0] = 2'(GrpA); ord[1] = 2'(GrpC); ord[2] = 2'(GrpB); end
      3'd2:    begin ord[0] = 2'(GrpB); ord[1] = 2'(GrpA); ord[2] = 2'(GrpC); end
      3'd3:    begin ord[0] = 2'(GrpB); ord[1] = 2'(GrpC); ord[2] = 2'(GrpA); end
      3'd4:    begin ord[0] = 2'(GrpC); ord[1] = 2'(GrpA); ord[2] = 2'(GrpB); end
      3'd5:    begin ord[0] = 2'(GrpC); ord[1] = 2'(GrpB); ord[2] = 2'(GrpA); end
      default: begin ord[0] = 2'(GrpA); ord[1] = 2'(GrpB); ord[2] = 2'(GrpC); end
    endcase
  end

  always_comb begin
    found  = 1'b0;
    winner = '0;
    for (int k = 0; k < NumGroups; k++) begin
      if (!found && grpValid[ord[k]]) begin
        winner = grpLvl[ord[k]];
        found  = 1'b1;
      end
    end
  end

  assign intOut   = gieQ && (active != '0);
  assign intLevel = intOut ? winner : '0;

  always_comb begin
    strobe.clrPend = (intAck && intOut) ? (RegW'(1) << winner) : '0;
    strobe.gieSet  = enCmd;
    strobe.gieClr  = disCmd;
  end

  a_r4_gated_by_gie: assert property (@(posedge clk) disable iff (!rstN)
    !gieQ |-> !intOut);

  a_r7_winner_live: assert property (@(posedge clk) disable iff (!rstN)
    intOut |-> (maskQ[intLevel] && pendQ[intLevel]));

  a_r5_dis_wins: assert property (@(posedge clk) disable iff (!rstN)
    disCmd |=> !gieQ);

  a_r5_en_sets: assert property (@(posedge clk) disable iff (!rstN)
    (enCmd && !disCmd) |=> gieQ);
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [RegW-1:0]   reqIn,
  input  logic              regWrEn,
  input  logic [1:0]        regSel,
  input  logic [RegW-1:0]   regWrData,
  output logic [RegW-1:0]   regRdData,
  input  logic              enCmd,
  input  logic              disCmd,
  input  logic              intAck,
  output logic              intOut,
  output logic [LevelW-1:0] intLevel
);
  ctlStrobe_t       strobe;
  logic [RegW-1:0]  maskQ;
  logic [PrioW-1:0] prioQ;
  logic [RegW-1:0]  pendQ;
  logic             gieQ;

  irqc_datapath u_dp (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .regWrEn(regWrEn),
    .regSel(regSel), .regWrData(regWrData), .strobe(strobe),
    .maskQ(maskQ), .prioQ(prioQ), .pendQ(pendQ), .gieQ(gieQ),
    .regRdData(regRdData)
  );

  irqc_control u_ctl (
    .clk(clk), .rstN(rstN), .maskQ(maskQ), .prioQ(prioQ), .pendQ(pendQ),
    .gieQ(gieQ), .enCmd(enCmd), .disCmd(disCmd), .intAck(intAck),
    .strobe(strobe), .intOut(intOut), .intLevel(intLevel)
  );
endmodule

// File: tb/test_irqc_top.sv
`timescale 1ns/1ps
module test_irqc_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] reqIn = '0;
  logic       regWrEn = 1'b0;
  logic [1:0] regSel = '0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic       enCmd = 1'b0, disCmd = 1'b0, intAck = 1'b0;
  logic       intOut;
  logic [2:0] intLevel;

  always #5 clk = ~clk;

  irqc_top i_irqc_top (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .regRdData(regRdData), .enCmd(enCmd),
    .disCmd(disCmd), .intAck(intAck), .intOut(intOut), .intLevel(intLevel)
  );

  typedef struct {
    string      tag;
    bit         isRead;
    logic [7:0] expVal;
  } sbItem_t;

  sbItem_t sbQ[$];
  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  // monitor: compares away from the active edge
  always @(negedge clk) begin
    while (sbQ.size() > 0) begin
      sbItem_t it;
      logic [7:0] act;
      it = sbQ.pop_front();
      act = it.isRead ? regRdData : {4'b0, intOut, intLevel};
      vectors++;
      if (act !== it.expVal) begin
        miscompares++;
        $display("FAIL %s: %s actual=%h expected=%h", it.tag,
                 it.isRead ? "read" : "{int,level}", act, it.expVal);
      end
    end
  end

  task automatic drive(input logic en, input logic dis, input logic ack,
                       input logic [7:0] req, input logic we,
                       input logic [1:0] sel, input logic [7:0] data);
    enCmd = en; disCmd = dis; intAck = ack; reqIn = req;
    regWrEn = we; regSel = sel; regWrData = data;
    @(posedge clk); #1;
    enCmd = 0; disCmd = 0; intAck = 0; reqIn = '0; regWrEn = 0;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] data);
    drive(0, 0, 0, 8'h00, 1, sel, data);
  endtask

  task automatic expOut(input string tag, input logic e, input logic [2:0] lvl);
    sbItem_t it;
    it.tag = tag; it.isRead = 1'b0; it.expVal = {4'b0, e, lvl};
    sbQ.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic expRd(input string tag, input logic [1:0] sel, input logic [7:0] v);
    sbItem_t it;
    regSel = sel;
    it.tag = tag; it.isRead = 1'b1; it.expVal = v;
    sbQ.push_back(it);
    @(negedge clk); #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R1 reset state
    expRd("R1 mask", 2'd0, 8'h00);
    expRd("R1 prio", 2'd1, 8'h00);
    expRd("R1 pend", 2'd2, 8'h00);
    expRd("R1 sys", 2'd3, 8'h00);
    expOut("R1 out", 0, 3'd0);
    // R2 unimplemented mask bits
    wr(2'd0, 8'hFF);
    expRd("R2 mask", 2'd0, 8'hD3);
    // R11 one-cycle request, R4 still gated
    drive(0, 0, 0, 8'hFF, 0, 2'd0, 8'h00);
    expRd("R11 pend", 2'd2, 8'hD3);
    expOut("R4 gie off", 0, 3'd0);
    // R3 pending read-only
    wr(2'd2, 8'h00);
    expRd("R3 pend", 2'd2, 8'hD3);
    // R5 / R7 enable
    drive(1, 0, 0, 8'h00, 0, 2'd0, 8'h00);
    expOut("R7 enabled", 1, 3'd0);
    expRd("R5 sys", 2'd3, 8'h01);
    // R8 priority orderings with all levels live
    wr(2'd1, 8'h08); expOut("R8 A member", 1, 3'd1);
    wr(2'd1, 8'h02); expOut("R8 code2", 1, 3'd4);
    wr(2'd1, 8'h03); expOut("R8 code3", 1, 3'd4);
    wr(2'd1, 8'h04); expOut("R8 code4", 1, 3'd6);
    wr(2'd1, 8'h14); expOut("R8 C member", 1, 3'd7);
    wr(2'd1, 8'h05); expOut("R8 code5", 1, 3'd6);
    wr(2'd1, 8'h06); expOut("R8 code6", 1, 3'd0);
    wr(2'd1, 8'h01); expOut("R8 code1", 1, 3'd0);
    wr(2'd1, 8'hFF); expRd("R8 reserved", 2'd1, 8'h1F);
    wr(2'd1, 8'h00);
    // R9 acknowledge
    drive(0, 0, 1, 8'h00, 0, 2'd0, 8'h00);
    expRd("R9 pend", 2'd2, 8'hD2);
    expOut("R9 next", 1, 3'd1);
    // R10 ack collides with request
    drive(0, 0, 1, 8'h02, 0, 2'd0, 8'h00);
    expRd("R10 pend", 2'd2, 8'hD2);
    expOut("R10 out", 1, 3'd1);
    drive(0, 0, 1, 8'h00, 0, 2'd0, 8'h00);
    expOut("R9 to B", 1, 3'd4);
    // R8 code1 vs code0 with group A empty
    wr(2'd1, 8'h01); expOut("R8 code1 C>B", 1, 3'd6);
    wr(2'd1, 8'h00); expOut("R8 code0 B>C", 1, 3'd4);
    // R6 masking
    wr(2'd0, 8'h80); expOut("R6 only7", 1, 3'd7);
    wr(2'd0, 8'h00); expOut("R6 none", 0, 3'd0);
    expRd("R6 kept", 2'd2, 8'hD0);
    // R9 ack with no interrupt shown
    drive(0, 0, 1, 8'h00, 0, 2'd0, 8'h00);
    expRd("R9 idle ack", 2'd2, 8'hD0);
    wr(2'd0, 8'hFF); expOut("R6 restore", 1, 3'd4);
    // R4 / R5 disable
    drive(0, 1, 0, 8'h00, 0, 2'd0, 8'h00);
    expOut("R4 disabled", 0, 3'd0);
    expRd("R5 dis", 2'd3, 8'h00);
    expRd("R11 kept", 2'd2, 8'hD0);
    drive(1, 1, 0, 8'h00, 0, 2'd0, 8'h00);
    expRd("R5 both", 2'd3, 8'h00);
    wr(2'd3, 8'h01);
    expRd("R5 direct", 2'd3, 8'h01);
    expOut("R5 direct out", 1, 3'd4);
    wr(2'd3, 8'hFE);
    expRd("R2 sys bits", 2'd3, 8'h00);
    drive(1, 0, 0, 8'h00, 1, 2'd3, 8'h00);
    expRd("R5 cmd over write", 2'd3, 8'h01);
    // R2 requests on unimplemented positions
    drive(0, 0, 0, 8'h2C, 0, 2'd0, 8'h00);
    expRd("R2 req ignored", 2'd2, 8'hD0);
    @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule